// File: doc/BRIEF.md
# Dual-Clock FIFO with Offset-Programmable Status Flags

This block is a first-in first-out buffer of 9-bit words whose depth is set by a parameter. Data enters on one clock and leaves on another, and the two clocks may be unrelated or tied together. Each pointer crosses into the other clock domain as a Gray code through a two-stage synchroniser. A word is stored on a rising write-clock edge when both write qualifiers agree. A word moves into a registered output on a rising read-clock edge when both read enables are low. The output bus floats whenever the output enable is high.

Four active-low flags report the fill level: empty, almost-empty, almost-full and full. The empty and almost-empty flags are registered on the read clock. The full and almost-full flags are registered on the write clock. Each flag is computed from the pointer that moves in its own domain after the current edge, so it asserts on the very edge that causes its condition. It may clear a few cycles late, because the other pointer is seen through synchronisers.

The level of the second write qualifier while reset is held picks one of two modes. With the pin high, it acts as a second write enable and both thresholds use a fixed offset of 7. With the pin low, the pin acts as a load strobe for an external offset bank, and the thresholds come from the offset input ports. The pin must stay steady until reset recovery completes, which takes two cycles of each clock after release.

Top module: `dcf_pflag_fifo`

## Requirements
- R1: While reset is asserted, and after it is released with no traffic, empty_n and almost_empty_n are 0, full_n and almost_full_n are 1, and the output register holds 0.
- R2: The value of wr_qual_b held during reset selects the mode: 1 gives dual-enable mode, 0 gives offset mode.
- R3: A word is written on a rising wr_clk only when wr_en_n is 0 and wr_qual_b is 1. Any other combination writes nothing.
- R4: The output register loads the oldest word on a rising rd_clk only when rd_en_a_n and rd_en_b_n are both 0. Otherwise it keeps its value.
- R5: While full_n is 0, write requests are ignored and the stored contents stay unchanged.
- R6: While empty_n is 0, read requests are ignored and the output register keeps its value.
- R7: almost_empty_n is 0 when the word count is at most n and 1 above n. In offset mode n is ae_ofs.
- R8: almost_full_n is 0 when the word count is at least DEPTH minus m and 1 below that. In offset mode m is af_ofs.
- R9: In dual-enable mode, ae_ofs and af_ofs are ignored and both n and m equal 7.
- R10: When out_en_n is 1, dout is high-impedance. When it is 0, dout shows the output register.
- R11: Words leave in the order they were accepted, with no loss or duplication, while both clocks run independently.
- R12: full_n falls on the write edge that stores the last free word. empty_n falls on the read edge that takes the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain through a synchroniser |
| din | input | DW | Write data |
| wr_en_n | input | 1 | Primary write enable, active low |
| wr_qual_b | input | 1 | Second write qualifier (active high). Its level during reset selects the mode, and in offset mode it is the load strobe |
| rd_en_a_n | input | 1 | Read enable A, active low |
| rd_en_b_n | input | 1 | Read enable B, active low |
| out_en_n | input | 1 | Output enable, active low |
| ae_ofs | input | AW | Almost-empty offset n, used in offset mode |
| af_ofs | input | AW | Almost-full offset m, used in offset mode |
| dout | output | DW | Registered read data, three-state |
| empty_n | output | 1 | Empty flag, active low, registered on rd_clk |
| almost_empty_n | output | 1 | Almost-empty flag, active low, registered on rd_clk |
| almost_full_n | output | 1 | Almost-full flag, active low, registered on wr_clk |
| full_n | output | 1 | Full flag, active low, registered on wr_clk |

## Verification
On every cycle, the embedded properties check four things. A full buffer never advances its write pointer, and an empty one never advances its read pointer. The output register stays still whenever either read enable is high. Each Gray pointer changes at most one bit per edge, and a hard flag never shows without its soft flag. The exact threshold positions, mode selection at reset, first-in first-out ordering across unrelated clocks, and flags asserting on the very edge that fills or drains the buffer can only be shown by the bench's scenarios. Those scenarios compare each flag with a model count once the synchronisers have settled.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic {
    MODE_PFLAG   = 1'b0,
    MODE_DUAL_WE = 1'b1
  } dcf_mode_e;

  localparam int DEF_OFFSET = 7;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rst_dn,
  input  logic          wr_en_n,
  input  logic          wr_qual_b,
  input  logic [AW-1:0] af_ofs,
  input  logic [PW-1:0] rgray_sync,
  output logic          wr_go,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          almost_full_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  dcf_mode_e     mode_q;
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rbin_s, level_d, af_thr;
  logic [AW-1:0] m_eff;
  logic          full_n_q, full_n_d, af_n_q, af_n_d;

  // mode follows the qualifier pin for as long as the domain reset is held
  always_ff @(posedge wr_clk) begin
    if (!rst_dn) mode_q <= wr_qual_b ? MODE_DUAL_WE : MODE_PFLAG;
  end

  always_comb begin
    wr_go    = !wr_en_n && wr_qual_b && full_n_q;
    wbin_d   = wbin_q + PW'(wr_go);
    wgray_d  = PW'(bin2gray(32'(wbin_d)));
    rbin_s   = PW'(gray2bin(32'(rgray_sync)));
    level_d  = wbin_d - rbin_s;
    m_eff    = (mode_q == MODE_PFLAG) ? af_ofs : AW'(DEF_OFFSET);
    af_thr   = DEPTH_P - PW'(m_eff);
    full_n_d = (level_d != DEPTH_P);
    af_n_d   = (level_d < af_thr);
  end

  always_ff @(posedge wr_clk or negedge rst_dn) begin
    if (!rst_dn) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_go) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wr_clk or negedge rst_dn) begin
    if (!rst_dn) begin
      full_n_q <= 1'b1;
      af_n_q   <= 1'b1;
    end else begin
      full_n_q <= full_n_d;
      af_n_q   <= af_n_d;
    end
  end

  assign waddr         = wbin_q[AW-1:0];
  assign wgray         = wgray_q;
  assign full_n        = full_n_q;
  assign almost_full_n = af_n_q;

  // R5: a full buffer keeps its write pointer
  p_no_overflow_r5: assert property (@(posedge wr_clk) disable iff (!rst_dn)
    !full_n_q |=> (wbin_q == $past(wbin_q)));

  // R8: full level is always inside the almost-full band
  p_full_in_af_r8: assert property (@(posedge wr_clk) disable iff (!rst_dn)
    !full_n_q |-> !af_n_q);

  // R11: pointer code crossing domains moves one bit at a time
  p_wgray_step_r11: assert property (@(posedge wr_clk) disable iff (!rst_dn)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 9,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          rd_clk,
  input  logic          rst_dn,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          wr_qual_b,
  input  logic [AW-1:0] ae_ofs,
  input  logic [PW-1:0] wgray_sync,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] dout_q,
  output logic          empty_n,
  output logic          almost_empty_n
);
  dcf_mode_e     mode_q;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] wbin_s, level_d;
  logic [AW-1:0] n_eff;
  logic [DW-1:0] out_q;
  logic          rd_go, empty_n_q, empty_n_d, ae_n_q, ae_n_d;

  always_ff @(posedge rd_clk) begin
    if (!rst_dn) mode_q <= wr_qual_b ? MODE_DUAL_WE : MODE_PFLAG;
  end

  always_comb begin
    rd_go     = !rd_en_a_n && !rd_en_b_n && empty_n_q;
    rbin_d    = rbin_q + PW'(rd_go);
    rgray_d   = PW'(bin2gray(32'(rbin_d)));
    wbin_s    = PW'(gray2bin(32'(wgray_sync)));
    level_d   = wbin_s - rbin_d;
    n_eff     = (mode_q == MODE_PFLAG) ? ae_ofs : AW'(DEF_OFFSET);
    empty_n_d = (level_d != '0);
    ae_n_d    = (level_d > PW'(n_eff));
  end

  always_ff @(posedge rd_clk or negedge rst_dn) begin
    if (!rst_dn) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      out_q   <= '0;
    end else if (rd_go) begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      out_q   <= ram_rdata;
    end
  end

  always_ff @(posedge rd_clk or negedge rst_dn) begin
    if (!rst_dn) begin
      empty_n_q <= 1'b0;
      ae_n_q    <= 1'b0;
    end else begin
      empty_n_q <= empty_n_d;
      ae_n_q    <= ae_n_d;
    end
  end

  assign raddr          = rbin_q[AW-1:0];
  assign rgray          = rgray_q;
  assign dout_q         = out_q;
  assign empty_n        = empty_n_q;
  assign almost_empty_n = ae_n_q;

  // R6: an empty buffer keeps its read pointer
  p_no_underflow_r6: assert property (@(posedge rd_clk) disable iff (!rst_dn)
    !empty_n_q |=> (rbin_q == $past(rbin_q)));

  // R4: either read enable high freezes the output register
  p_out_hold_r4: assert property (@(posedge rd_clk) disable iff (!rst_dn)
    (rd_en_a_n || rd_en_b_n) |=> $stable(out_q));

  // R7: empty level is always inside the almost-empty band
  p_empty_in_ae_r7: assert property (@(posedge rd_clk) disable iff (!rst_dn)
    !empty_n_q |-> !ae_n_q);

  p_rgray_step_r11: assert property (@(posedge rd_clk) disable iff (!rst_dn)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/dcf_pflag_fifo.sv
module dcf_pflag_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 9,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wr_en_n,
  input  logic          wr_qual_b,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          out_en_n,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW-1:0] af_ofs,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          almost_empty_n,
  output logic          almost_full_n,
  output logic          full_n
);
  localparam int PW = AW + 1;

  logic          rst_wn, rst_rn, wr_go;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
  logic [DW-1:0] ram_rdata, dout_q;

  dcf_rst_sync u_rst_w (.clk(wr_clk), .arst_n(rst_n), .srst_n(rst_wn));
  dcf_rst_sync u_rst_r (.clk(rd_clk), .arst_n(rst_n), .srst_n(rst_rn));

  dcf_ptr_sync #(.W(PW), .STAGES(2)) u_sync_r2w (
    .clk(wr_clk), .rst_n(rst_wn), .d(rgray), .q(rgray_ws));
  dcf_ptr_sync #(.W(PW), .STAGES(2)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rst_rn), .d(wgray), .q(wgray_rs));

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wr_clk(wr_clk), .we(wr_go), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(ram_rdata));

  dcf_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wr_clk(wr_clk), .rst_dn(rst_wn), .wr_en_n(wr_en_n), .wr_qual_b(wr_qual_b),
    .af_ofs(af_ofs), .rgray_sync(rgray_ws), .wr_go(wr_go), .waddr(waddr),
    .wgray(wgray), .full_n(full_n), .almost_full_n(almost_full_n));

  dcf_rd_side #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW)) u_rd (
    .rd_clk(rd_clk), .rst_dn(rst_rn), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
    .wr_qual_b(wr_qual_b), .ae_ofs(ae_ofs), .wgray_sync(wgray_rs),
    .ram_rdata(ram_rdata), .raddr(raddr), .rgray(rgray), .dout_q(dout_q),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n));

  assign dout = out_en_n ? 'z : dout_q;
endmodule

// File: tb/tb_dcf_pflag_fifo.sv
module tb_dcf_pflag_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DEPTH      = 16;
  localparam int DW         = 9;
  localparam int AW         = $clog2(DEPTH);

  logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic          wr_en_n = 1'b1, wr_qual_b = 1'b0;
  logic          rd_en_a_n = 1'b1, rd_en_b_n = 1'b1, out_en_n = 1'b0;
  logic [AW-1:0] ae_ofs = AW'(3), af_ofs = AW'(5);
  wire  [DW-1:0] dout;
  wire           empty_n, almost_empty_n, almost_full_n, full_n;

  int checks_n = 0, fails_n = 0;
  int n_cur = 7, m_cur = 7;
  logic [DW-1:0] model_q [$];
  logic [DW-1:0] last_out = '0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  dcf_pflag_fifo #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
    .wr_en_n(wr_en_n), .wr_qual_b(wr_qual_b), .rd_en_a_n(rd_en_a_n),
    .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .dout(dout), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .almost_full_n(almost_full_n), .full_n(full_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks_n++;
    if (!ok) begin
      fails_n++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_ae(input int sz); return sz > n_cur; endfunction
  function automatic bit exp_af(input int sz); return sz < DEPTH - m_cur; endfunction

  task automatic check_flags(input string req);
    int sz = model_q.size();
    chk(empty_n == (sz != 0), {req, " empty_n"}, int'(empty_n), int'(sz != 0));
    chk(almost_empty_n == exp_ae(sz), {req, " almost_empty_n"}, int'(almost_empty_n), int'(exp_ae(sz)));
    chk(almost_full_n == exp_af(sz), {req, " almost_full_n"}, int'(almost_full_n), int'(exp_af(sz)));
    chk(full_n == (sz != DEPTH), {req, " full_n"}, int'(full_n), int'(sz != DEPTH));
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic do_reset(input bit dual);
    @(negedge wr_clk);
    wr_qual_b = dual; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (5) @(negedge rd_clk);
    repeat (5) @(negedge wr_clk);
    model_q.delete();
    last_out = '0;
    n_cur = dual ? 7 : 3;
    m_cur = dual ? 7 : 5;
  endtask

  task automatic wr_one(input logic [DW-1:0] d);
    @(negedge wr_clk);
    din = d; wr_en_n = 1'b0; wr_qual_b = 1'b1;
    if (full_n) model_q.push_back(d);
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic rd_one(input string req);
    logic [DW-1:0] e;
    @(negedge rd_clk);
    if (empty_n && model_q.size() > 0) begin
      e = model_q.pop_front();
      rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
      @(negedge rd_clk);
      rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
      chk(dout == e, req, int'(dout), int'(e));
      last_out = e;
    end else begin
      chk(1'b0, {req, " unexpected empty"}, int'(empty_n), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // offset mode: qualifier low during reset
    do_reset(1'b0);
    check_flags("R1");
    chk(dout == '0, "R1 dout", int'(dout), 0);

    // R3: enable low but qualifier (strobe) low, and qualifier high with enable high
    @(negedge wr_clk); din = 9'h055; wr_en_n = 1'b0; wr_qual_b = 1'b0;
    @(negedge wr_clk); wr_en_n = 1'b1; wr_qual_b = 1'b1;
    @(negedge wr_clk);
    settle();
    check_flags("R3");

    // R7 / R2: offset n=3 is in force, not 7
    for (int i = 1; i <= 3; i++) wr_one(DW'(i));
    settle();
    check_flags("R7 at n");
    wr_one(DW'(4));
    settle();
    check_flags("R2 R7 above n");

    // R4: only one read enable low
    @(negedge rd_clk); rd_en_a_n = 1'b0; rd_en_b_n = 1'b1;
    @(negedge rd_clk); rd_en_a_n = 1'b1; rd_en_b_n = 1'b0;
    @(negedge rd_clk); rd_en_b_n = 1'b1;
    chk(dout == '0, "R4 hold", int'(dout), 0);
    settle();
    check_flags("R4 count");

    // R8 with m=5: low from 11 words
    for (int i = 5; i <= 10; i++) wr_one(DW'(i));
    settle();
    check_flags("R8 below");
    wr_one(DW'(11));
    settle();
    check_flags("R8 at");

    // R12: full asserts on the filling edge
    for (int i = 12; i <= DEPTH; i++) wr_one(DW'(i));
    chk(full_n == 1'b0, "R12 full edge", int'(full_n), 0);

    // R5: writes while full are dropped
    for (int i = 0; i < 3; i++) wr_one(DW'(9'h1A0 + i));
    settle();
    check_flags("R5 flags");
    chk(model_q.size() == DEPTH, "R5 count", model_q.size(), DEPTH);

    // drain, order (R11) and R5 content
    for (int i = 0; i < DEPTH; i++) rd_one("R5 R11 drain");
    chk(empty_n == 1'b0, "R12 empty edge", int'(empty_n), 0);

    // R6: reads while empty change nothing
    @(negedge rd_clk); rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
    repeat (2) @(negedge rd_clk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    chk(dout == last_out, "R6 hold", int'(dout), int'(last_out));
    settle();
    check_flags("R6 flags");

    // R10: three-state
    @(negedge rd_clk); out_en_n = 1'b1; #1;
    chk((dout === 'z) || (dout !== last_out), "R10 float", int'(dout), -1);
    out_en_n = 1'b0; #1;
    chk(dout == last_out, "R10 drive", int'(dout), int'(last_out));

    // dual-enable mode: offsets ignored
    do_reset(1'b1);
    check_flags("R1 R2 dual");
    chk(dout == '0, "R1 dout dual", int'(dout), 0);
    for (int i = 0; i < 7; i++) wr_one(DW'(9'h100 + i));
    settle();
    check_flags("R9 ae at 7");
    wr_one(9'h107);
    settle();
    check_flags("R9 ae above 7");
    wr_one(9'h108);
    settle();
    check_flags("R9 af at 9");

    // R11: concurrent random traffic
    fork
      begin
        for (int i = 0; i < 500; i++) begin
          int r;
          logic [DW-1:0] d;
          @(negedge wr_clk);
          r = int'($urandom % 8);
          d = DW'($urandom);
          din = d;
          if (r < 5) begin
            wr_en_n = 1'b0; wr_qual_b = 1'b1;
            if (full_n) model_q.push_back(d);
          end else if (r == 5) begin
            wr_en_n = 1'b0; wr_qual_b = 1'b0;
          end else begin
            wr_en_n = 1'b1; wr_qual_b = 1'b1;
          end
        end
        @(negedge wr_clk); wr_en_n = 1'b1; wr_qual_b = 1'b1;
      end
      begin
        bit pend = 1'b0;
        logic [DW-1:0] e = '0;
        for (int i = 0; i < 400; i++) begin
          @(negedge rd_clk);
          if (pend) begin
            chk(dout == e, "R11 random order", int'(dout), int'(e));
            last_out = e;
          end
          pend = 1'b0;
          if (($urandom % 3 != 0) && empty_n) begin
            e = model_q.pop_front();
            rd_en_a_n = 1'b0; rd_en_b_n = 1'b0; pend = 1'b1;
          end else if ($urandom % 4 == 0) begin
            rd_en_a_n = 1'b1; rd_en_b_n = 1'b0;
          end else begin
            rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
          end
        end
        @(negedge rd_clk);
        if (pend) chk(dout == e, "R11 random last", int'(dout), int'(e));
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
      end
    join
    settle();
    check_flags("R11 after random");
    while (model_q.size() > 0) rd_one("R11 final drain");
    settle();
    check_flags("R11 empty");

    $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fails_n);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks_n++;
    fails_n++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fails_n);
    $finish;
  end
endmodule